// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a small three-wire serial EEPROM. Two device sizes are supported: one with 6-bit word addresses and one with 8-bit word addresses. A host pulses `start` with a device size and a word address. The block then raises chip select and clocks out a start bit, the read opcode and the address. It spends one serial clock on the zero bit the memory emits before its data, shifts in sixteen data bits, drops chip select and pulses `done`.

The serial clock comes from the system clock through an even divider, `SCLK_DIV`. Each bit slot spends its first half with the clock low and its second half with the clock high. The outgoing data line changes only at the start of a slot. The incoming line is sampled in the last system cycle of the high half. After each read, chip select stays low for one full slot before the block accepts another request.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is cleared to zero, including `rd_data`.
- R2: The first three bit slots of every frame carry 1, 1, 0 on `ee_mosi`.
- R3: After those three bits come the address bits, MSB first: 6 bits when `dev_wide` is 0 and 8 bits when `dev_wide` is 1.
- R4: When `dev_wide` is 0, bits 7 and 6 of `word_addr` have no effect on the frame or on the returned word.
- R5: The slot right after the address is a dummy slot and its sample is discarded. The next 16 samples form `rd_data`, and the first of them lands in bit 15.
- R6: `ee_mosi` is low from the dummy slot to the end of the frame, and it never changes while `ee_sclk` is high.
- R7: Each slot lasts `SCLK_DIV` system clocks. `ee_sclk` is low for the first `SCLK_DIV/2` clocks of the slot and high for the rest. The slot's first clock is the cycle after the accepting edge.
- R8: `ee_cs` goes high in the cycle after a request is accepted and stays high for exactly the frame's slots. It then stays low for `SCLK_DIV` clocks, and `busy` stays high during those clocks.
- R9: A `start` seen while `busy` is high has no effect. Changes to `dev_wide` or `word_addr` during a read have no effect on that read.
- R10: `done` is high for one clock, in the first cycle with `ee_cs` low after the frame. `rd_data` takes the new word in that same cycle and holds it until the next completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Read request, accepted while idle |
| dev_wide | input | 1 | 0: 6-bit address device, 1: 8-bit address device |
| word_addr | input | 8 | Word address |
| busy | output | 1 | A read or its closing gap is in progress |
| done | output | 1 | One-cycle pulse when the word is available |
| rd_data | output | 16 | Last word read |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sclk | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to the memory |
| ee_miso | input | 1 | Serial data from the memory |

## Verification
A wrong slot count or a wrong latched address length shows on `ee_mosi` within the same slot, because every cycle of the frame is compared against a timeline. A phase counter that drifts misplaces an `ee_sclk` edge within one slot. A dummy slot that is not skipped shows only at the end of the frame, as a word shifted by one bit. The bench memory drives 1 until the dummy slot, so the error cannot hide. A corrupted state register also shows up as an early or late `done` or `busy` edge.

// File: rtl/mw_rd_pkg.sv
// Shared definitions for the serial EEPROM word reader.
// Assumes a start bit followed by a two-bit read opcode, sent MSB first.
package mw_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } mw_state_e;

    localparam int unsigned OPC_W      = 3;
    localparam logic [2:0]  RD_OPCODE  = 3'b110;
endpackage

// File: rtl/mw_bit_timer.sv
// Slot phase counter and serial clock generator.
// Counts DIV system clocks per slot while run is high. The clock output is
// low for the first half of the slot and high for the second, and only
// while clk_en is high. Assumes DIV is even and at least 2.
module mw_bit_timer #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clk_en,
    output logic ph_last,
    output logic sclk
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PH_W-1:0] ph_q;
    logic            sclk_q;

    assign ph_last = (ph_q == PH_W'(DIV - 1));
    assign sclk    = sclk_q;

    // Advance the phase and form the registered serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end else if (run) begin
            if (ph_last) begin
                ph_q   <= '0;
                sclk_q <= 1'b0;
            end else begin
                ph_q   <= ph_q + 1'b1;
                sclk_q <= clk_en && (ph_q >= PH_W'(HALF - 1));
            end
        end else begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end
    end

    // R7: the clock is high only inside an active slot.
    a_r7_sclk_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> run);
    // R7: the clock falls only at a slot boundary.
    a_r7_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (ph_q == '0));
endmodule

// File: rtl/mw_rx_capture.sv
// Receive shifter for the serial data-in line.
// Shifts one bit per enabled cycle, MSB first. On load_en it moves the
// completed word, including the bit arriving that cycle, to the output,
// where it holds until the next load.
module mw_rx_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              miso,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] word_q;

    assign word = word_q;

    // Collect incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[DATA_W-2:0], miso};
    end

    // Publish the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (load_en) word_q <= {sr_q[DATA_W-2:0], miso};
    end

    // R5: the final bit is always one of the sampled ones.
    a_r5_load_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> shift_en);
    // R10: the word holds between loads.
    a_r10_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_en) && $past(rst_n) |-> $stable(word_q));
endmodule

// File: rtl/mw_frame_seq.sv
// Frame sequencer: accepts a request, latches the address and its length,
// drives chip select and data-out per slot, marks the data slots for
// sampling, and holds a one-slot gap after the frame.
// Assumes ph_last marks the final system clock of each slot.
module mw_frame_seq
    import mw_rd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SHORT_AW = 6,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dev_wide,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              ph_last,
    output logic              run,
    output logic              clk_en,
    output logic              cs,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              shift_en,
    output logic              load_en
);
    localparam int unsigned TX_W      = OPC_W + ADDR_W;
    localparam int unsigned MAX_SLOTS = TX_W + 1 + DATA_W;
    localparam int unsigned SL_W      = $clog2(MAX_SLOTS);
    localparam int unsigned PAD_W     = ADDR_W - SHORT_AW;

    mw_state_e         state_q;
    logic [SL_W-1:0]   slot_q;
    logic [SL_W-1:0]   first_data_q;
    logic [SL_W-1:0]   last_slot_q;
    logic [TX_W-1:0]   tx_q;
    logic              cs_q;
    logic              mosi_q;
    logic              done_q;

    logic              accept;
    logic              slot_end;
    logic              final_slot;
    logic [ADDR_W-1:0] addr_aligned;
    logic [TX_W-1:0]   frame;
    logic [SL_W-1:0]   first_data_d;

    // Request acceptance, slot events and frame assembly.
    always_comb begin
        accept       = (state_q == ST_IDLE) && start;
        slot_end     = (state_q == ST_FRAME) && ph_last;
        final_slot   = slot_end && (slot_q == last_slot_q);
        addr_aligned = dev_wide ? word_addr
                                : {word_addr[SHORT_AW-1:0], {PAD_W{1'b0}}};
        frame        = {RD_OPCODE, addr_aligned};
        first_data_d = dev_wide ? SL_W'(TX_W + 1) : SL_W'(OPC_W + SHORT_AW + 1);
    end

    assign run      = (state_q != ST_IDLE);
    assign clk_en   = (state_q == ST_FRAME);
    assign busy     = run;
    assign cs       = cs_q;
    assign mosi     = mosi_q;
    assign done     = done_q;
    assign shift_en = slot_end && (slot_q >= first_data_q);
    assign load_en  = final_slot;

    // Top-level state: idle, frame, closing gap.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            case (state_q)
                ST_IDLE:  if (accept)     state_q <= ST_FRAME;
                ST_FRAME: if (final_slot) state_q <= ST_GAP;
                ST_GAP:   if (ph_last)    state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    // Slot index and the slot limits latched for this read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q       <= '0;
            first_data_q <= '0;
            last_slot_q  <= '0;
        end else if (accept) begin
            slot_q       <= '0;
            first_data_q <= first_data_d;
            last_slot_q  <= first_data_d + SL_W'(DATA_W - 1);
        end else if (slot_end) begin
            slot_q       <= slot_q + 1'b1;
        end
    end

    // Outgoing bit stream: opcode and address, then zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (accept) begin
            mosi_q <= frame[TX_W-1];
            tx_q   <= frame << 1;
        end else if (slot_end) begin
            mosi_q <= final_slot ? 1'b0 : tx_q[TX_W-1];
            tx_q   <= tx_q << 1;
        end
    end

    // Chip select and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (accept)          cs_q <= 1'b1;
            else if (final_slot) cs_q <= 1'b0;
            done_q <= final_slot;
        end
    end

    // R6: data-out stays low from the dummy slot onward.
    a_r6_mosi_low_late: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q && (slot_q + 1'b1 >= first_data_q) |-> !mosi_q);
    // R8: chip select implies busy.
    a_r8_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> busy);
    // R9: a frame in progress is never restarted.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME) && !slot_end |=> $stable(slot_q));
endmodule

// File: rtl/mw_eeprom_reader.sv
// Top level of the serial EEPROM word reader. Connects the slot timer,
// the frame sequencer and the receive shifter.
// Assumes SCLK_DIV is even and at least 2, and SHORT_AW < ADDR_W.
module mw_eeprom_reader #(
    parameter int unsigned SCLK_DIV = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SHORT_AW = 6,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dev_wide,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_mosi,
    input  logic              ee_miso
);
    logic run;
    logic clk_en;
    logic ph_last;
    logic shift_en;
    logic load_en;

    mw_bit_timer #(.DIV(SCLK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_en  (clk_en),
        .ph_last (ph_last),
        .sclk    (ee_sclk)
    );

    mw_frame_seq #(
        .ADDR_W   (ADDR_W),
        .SHORT_AW (SHORT_AW),
        .DATA_W   (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dev_wide  (dev_wide),
        .word_addr (word_addr),
        .ph_last   (ph_last),
        .run       (run),
        .clk_en    (clk_en),
        .cs        (ee_cs),
        .mosi      (ee_mosi),
        .busy      (busy),
        .done      (done),
        .shift_en  (shift_en),
        .load_en   (load_en)
    );

    mw_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .miso     (ee_miso),
        .word     (rd_data)
    );

    // R6: data-out holds while the serial clock is high.
    a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk && $past(ee_sclk) |-> $stable(ee_mosi));
    // R8: no serial clock without chip select.
    a_r8_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> ee_cs);
    // R10: done lasts one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done coincides with the fall of chip select.
    a_r10_done_at_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ee_cs && $past(ee_cs));
endmodule

// File: tb/mw_eeprom_reader_bench.sv
// Bench: behavioural timeline model compared every cycle, plus a memory model.
module mw_eeprom_reader_bench;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dev_wide = 1'b0;
    logic [7:0]  word_addr = 8'h00;
    logic        busy, done, ee_cs, ee_sclk, ee_mosi;
    logic        ee_miso = 1'b1;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mw_eeprom_reader #(.SCLK_DIV(DIV)) u_mw_eeprom_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_wide(dev_wide),
        .word_addr(word_addr), .busy(busy), .done(done), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
    );

    function automatic logic [15:0] mem_word(int a);
        logic [7:0] b;
        b = 8'(a);
        return {b ^ 8'hA5, 8'(b * 8'd7) ^ 8'h5A};
    endfunction

    // Timeline model
    bit          m_busy = 0;
    int          m_t = 0;
    int          m_alen = 6;
    int          m_addr = 0;
    int          m_ns = 0;
    logic [15:0] m_rdata = 16'h0;
    logic [15:0] m_exp = 16'h0;

    function automatic logic fbit(int s);
        if (s < 3) return (s < 2);
        if (s < 3 + m_alen) return 1'(m_addr >> (m_alen - 1 - (s - 3)));
        return 1'b0;
    endfunction

    function automatic string do_tag(int s);
        if (s < 3) return "R2";
        if (s < 3 + m_alen) return "R3";
        return "R6";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_rdata = 16'h0;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_t = 0;
                m_alen = dev_wide ? 8 : 6;
                m_addr = dev_wide ? int'(word_addr) : int'(word_addr & 8'h3F);
                m_ns   = 3 + m_alen + 1 + 16;
                m_exp  = mem_word(m_addr);
            end
        end else begin
            m_t = m_t + 1;
            if (m_t == m_ns * DIV) m_rdata = m_exp;
            if (m_t == m_ns * DIV + DIV) m_busy = 0;
        end
    end

    // Memory model: answers on each rising serial clock.
    int         s_cnt = 0;
    logic [7:0] s_addr = 8'h0;
    always @(posedge ee_sclk or negedge ee_cs) begin
        if (!ee_cs) begin
            s_cnt = 0; s_addr = 8'h0; ee_miso = 1'b1;
        end else begin
            s_cnt = s_cnt + 1;
            if (s_cnt > 3 && s_cnt <= 3 + m_alen) s_addr = {s_addr[6:0], ee_mosi};
            if (s_cnt == 4 + m_alen) ee_miso = 1'b0;
            else if (s_cnt >= 5 + m_alen && s_cnt <= 20 + m_alen)
                ee_miso = mem_word(int'(s_addr))[15 - (s_cnt - 5 - m_alen)];
        end
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_cs, e_sclk, e_do, e_done;
            int   s;
            e_cs   = m_busy && (m_t < m_ns * DIV);
            e_sclk = e_cs && ((m_t % DIV) >= HALF);
            s      = m_t / DIV;
            e_do   = e_cs ? fbit(s) : 1'b0;
            e_done = m_busy && (m_t == m_ns * DIV);
            chk(ee_cs == e_cs, "R8", "ee_cs", 32'(ee_cs), 32'(e_cs));
            chk(ee_sclk == e_sclk, "R7", "ee_sclk", 32'(ee_sclk), 32'(e_sclk));
            chk(ee_mosi == e_do, e_cs ? do_tag(s) : "R6", "ee_mosi", 32'(ee_mosi), 32'(e_do));
            chk(busy == m_busy, "R9", "busy", 32'(busy), 32'(m_busy));
            chk(done == e_done, "R10", "done", 32'(done), 32'(e_done));
            chk(rd_data == m_rdata, "R5", "rd_data", 32'(rd_data), 32'(m_rdata));
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    task automatic do_read(bit wide, logic [7:0] a);
        @(negedge clk);
        dev_wide = wide; word_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy, done, ee_cs, ee_sclk, ee_mosi} == 5'b0 && rd_data == 16'h0,
            "R1", "reset outputs", {11'h0, busy, done, ee_cs, ee_sclk, ee_mosi, rd_data},
            32'h0);
        start = 1'b0;
        rst_n = 1'b1;

        do_read(1'b0, 8'h15);
        do_read(1'b0, 8'hD5);
        chk(rd_data == mem_word(8'h15), "R4", "narrow upper bits ignored",
            32'(rd_data), 32'(mem_word(8'h15)));
        do_read(1'b1, 8'hD5);
        chk(rd_data == mem_word(8'hD5), "R3", "wide address",
            32'(rd_data), 32'(mem_word(8'hD5)));
        do_read(1'b1, 8'h00);
        do_read(1'b1, 8'hFF);
        do_read(1'b0, 8'h3F);

        // R9: start and input changes during a read are ignored
        @(negedge clk);
        dev_wide = 1'b1; word_addr = 8'h81; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        dev_wide = 1'b0; word_addr = 8'h22; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(rd_data == mem_word(8'h81), "R9", "read unaffected by mid-read request",
            32'(rd_data), 32'(mem_word(8'h81)));

        // R8: start held high across the closing gap
        @(negedge clk);
        dev_wide = 1'b0; word_addr = 8'h2A; start = 1'b1;
        @(negedge clk);
        wait_idle();
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(rd_data == mem_word(8'h2A), "R10", "held value after back-to-back reads",
            32'(rd_data), 32'(mem_word(8'h2A)));

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule